// File: doc/BRIEF.md
# Processor Presence Bitmap with Hot-Plug Event

This block records which processors are present in a system as a bitmap with one bit per processor identifier. The bitmap is laid out as a row of bytes: identifier `n` lives in byte `n/8`, bit `n%8`. Software reads the bitmap one byte at a time through a small read port. Any write it makes to the bitmap region is accepted and dropped.

A plug request sets a processor's bit and an unplug request clears it. Both kinds of request also latch a shared processor-event flag in a general-purpose event status byte. A second flag in the same byte is raised by a slot hot-plug source. Software clears these flags with a write-one-to-clear. An interrupt level is formed from the status byte, masked by an enable byte.

At reset the bitmap is loaded from a presence vector, so processors present at boot are marked without raising an event. A request whose identifier falls outside the bitmap is rejected with a one-cycle error pulse.

Top module: `cpu_presence_map`

## Requirements
- R1: A plug request (`reqValid`=1, `reqPlug`=1) with an in-range identifier sets bit `reqId%8` of byte `reqId/8`. The change is visible on `rdData` in the cycle after the request's clock edge.
- R2: An unplug request (`reqValid`=1, `reqPlug`=0) with an in-range identifier clears that same bit. No other bit changes.
- R3: Every in-range plug or unplug request sets status bit 2 (value 0x04), whatever value the map bit had before.
- R4: `rdData` is the byte at `rdOffset`, read combinationally from the stored map. Offsets at or above `MAP_BYTES` read 0x00.
- R5: A write to the bitmap region (`mapWrValid`, `mapWrOffset`, `mapWrData`) changes no map byte and no status bit.
- R6: While reset is asserted, the map holds `initPresent`, with byte k taken from bits [8k+7:8k]. The status byte is 0x00, and `irq` and `errPulse` are low.
- R7: A `slotEvtSet` pulse sets status bit 1 (value 0x02). All status bits other than 1 and 2 always read 0.
- R8: An identifier whose byte index `reqId/8` is at or above `MAP_BYTES` raises `errPulse` for exactly the next cycle. Such a request changes neither the map nor the status.
- R9: With `stsClrValid`=1, each status bit set in `stsClrMask` is cleared. A set from a request or a slot event in the same cycle takes priority over the clear.
- R10: `irq` is high exactly when `evtStatus & evtEnable` has bit 1 or bit 2 set. It follows `evtEnable` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; loads the map from `initPresent` |
| initPresent | input | MAP_BYTES*8 | Boot-time presence vector, bit n = identifier n |
| reqValid | input | 1 | Plug/unplug request strobe |
| reqPlug | input | 1 | 1 = plug, 0 = unplug |
| reqId | input | 8 | Processor identifier of the request |
| rdOffset | input | clog2(MAP_BYTES) | Byte offset for reads |
| rdData | output | 8 | Map byte at `rdOffset` |
| mapWrValid | input | 1 | Write to the bitmap region (dropped) |
| mapWrOffset | input | clog2(MAP_BYTES) | Offset of the dropped write |
| mapWrData | input | 8 | Data of the dropped write |
| slotEvtSet | input | 1 | Slot hot-plug event, sets status bit 1 |
| stsClrValid | input | 1 | Write-one-to-clear strobe for the status byte |
| stsClrMask | input | 8 | Bits to clear in the status byte |
| evtEnable | input | 8 | Event enable mask |
| evtStatus | output | 8 | Event status byte |
| irq | output | 1 | Interrupt level |
| errPulse | output | 1 | One-cycle pulse on an out-of-range identifier |

## Verification
A wrong bit placement or a lost update shows up on `rdData` the first cycle software reads the affected byte. If the bench reads that offset on the next cycle, the error appears one cycle after the faulty edge. A missing or stuck status bit shows on `evtStatus` in the cycle right after the edge, and on `irq` in the same cycle whenever the matching enable is set. Because the reference model is compared on every clock, with random offsets and enables, a divergence is reported within a few cycles of the edge that caused it. The bench uses a map shorter than the 8-bit identifier range, so that rejected identifiers and the zero read of unmapped offsets can occur at all.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int ID_W         = 8;
  localparam int BIT_IDX_W    = 3;
  localparam int BYTE_IDX_W   = ID_W - BIT_IDX_W;
  localparam int BYTE_W       = 8;
  localparam int STS_W        = 8;
  localparam int CPU_EVT_BIT  = 2;
  localparam int SLOT_EVT_BIT = 1;
  localparam logic [STS_W-1:0] KNOWN_MASK =
    STS_W'((1 << CPU_EVT_BIT) | (1 << SLOT_EVT_BIT));

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic                  mapWe;
    logic                  mapVal;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic [BIT_IDX_W-1:0]  bitIdx;
    logic                  cpuEvt;
    logic                  slotEvt;
    logic [STS_W-1:0]      clrMask;
  } cpmStrobes_t;
endpackage

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
#(
  parameter int MAP_BYTES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqPlug,
  input  logic [ID_W-1:0]  reqId,
  input  logic             slotEvtSet,
  input  logic             stsClrValid,
  input  logic [STS_W-1:0] stsClrMask,
  output cpmStrobes_t      strb,
  output logic             errPulse
);
  localparam int ID_SPAN = 1 << ID_W;

  logic inRange;

  generate
    if (MAP_BYTES * BYTE_W >= ID_SPAN) begin : g_fullRange
      assign inRange = 1'b1;
    end else begin : g_partRange
      assign inRange = int'(reqId[ID_W-1:BIT_IDX_W]) < MAP_BYTES;
    end
  endgenerate

  always_comb begin
    strb.mapWe   = reqValid & inRange;
    strb.mapVal  = reqPlug;
    strb.byteIdx = reqId[ID_W-1:BIT_IDX_W];
    strb.bitIdx  = reqId[BIT_IDX_W-1:0];
    strb.cpuEvt  = reqValid & inRange;
    strb.slotEvt = slotEvtSet;
    strb.clrMask = stsClrValid ? stsClrMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= reqValid & ~inRange;
  end
endmodule

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int MAP_BYTES = 32,
  localparam int OFS_W    = $clog2(MAP_BYTES),
  localparam int MAP_BITS = MAP_BYTES * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MAP_BITS-1:0] initPresent,
  input  cpmStrobes_t         strb,
  input  logic [OFS_W-1:0]    rdOffset,
  input  logic [STS_W-1:0]    evtEnable,
  output logic [BYTE_W-1:0]   rdData,
  output logic [STS_W-1:0]    evtStatus,
  output logic                irq
);
  logic [MAP_BYTES-1:0][BYTE_W-1:0] presentMap;
  logic [STS_W-1:0] setBits;
  logic [STS_W-1:0] statusNext;

  // Presence bytes: one register per byte, written by the request strobe
  for (genvar b = 0; b < MAP_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        presentMap[b] <= initPresent[b*BYTE_W +: BYTE_W];
      end else if (strb.mapWe && int'(strb.byteIdx) == b) begin
        presentMap[b][strb.bitIdx] <= strb.mapVal;
      end
    end
  end

  generate
    if ((1 << OFS_W) > MAP_BYTES) begin : g_rdGuard
      assign rdData = (int'(rdOffset) < MAP_BYTES) ? presentMap[rdOffset] : '0;
    end else begin : g_rdFull
      assign rdData = presentMap[rdOffset];
    end
  endgenerate

  // Status: sets take priority over write-one-to-clear
  always_comb begin
    setBits = '0;
    setBits[CPU_EVT_BIT]  = strb.cpuEvt;
    setBits[SLOT_EVT_BIT] = strb.slotEvt;
    statusNext = ((evtStatus & ~strb.clrMask) | setBits) & KNOWN_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtStatus <= '0;
    else       evtStatus <= statusNext;
  end

  assign irq = |(evtStatus & evtEnable & KNOWN_MASK);
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
  import cpm_pkg::*;
#(
  parameter int MAP_BYTES = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [MAP_BYTES*8-1:0]            initPresent,
  input  logic                              reqValid,
  input  logic                              reqPlug,
  input  logic [7:0]                        reqId,
  input  logic [$clog2(MAP_BYTES)-1:0]      rdOffset,
  output logic [7:0]                        rdData,
  input  logic                              mapWrValid,
  input  logic [$clog2(MAP_BYTES)-1:0]      mapWrOffset,
  input  logic [7:0]                        mapWrData,
  input  logic                              slotEvtSet,
  input  logic                              stsClrValid,
  input  logic [7:0]                        stsClrMask,
  input  logic [7:0]                        evtEnable,
  output logic [7:0]                        evtStatus,
  output logic                              irq,
  output logic                              errPulse
);
  cpmStrobes_t strb;

  cpm_ctrl #(.MAP_BYTES(MAP_BYTES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPlug    (reqPlug),
    .reqId      (reqId),
    .slotEvtSet (slotEvtSet),
    .stsClrValid(stsClrValid),
    .stsClrMask (stsClrMask),
    .strb       (strb),
    .errPulse   (errPulse)
  );

  cpm_datapath #(.MAP_BYTES(MAP_BYTES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .initPresent(initPresent),
    .strb       (strb),
    .rdOffset   (rdOffset),
    .evtEnable  (evtEnable),
    .rdData     (rdData),
    .evtStatus  (evtStatus),
    .irq        (irq)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int MAP_BYTES = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         reqValid,
  input logic                         reqPlug,
  input logic [7:0]                   reqId,
  input logic [$clog2(MAP_BYTES)-1:0] rdOffset,
  input logic [7:0]                   rdData,
  input logic                         mapWrValid,
  input logic [$clog2(MAP_BYTES)-1:0] mapWrOffset,
  input logic [7:0]                   mapWrData,
  input logic                         slotEvtSet,
  input logic                         stsClrValid,
  input logic [7:0]                   stsClrMask,
  input logic [7:0]                   evtStatus,
  input logic                         errPulse
);
  logic goodReq;
  logic badReq;
  assign goodReq = reqValid && (int'(reqId[7:3]) < MAP_BYTES);
  assign badReq  = reqValid && !(int'(reqId[7:3]) < MAP_BYTES);

  AST_PLUG_SETS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    goodReq && reqPlug |=> (int'(rdOffset) != int'($past(reqId[7:3]))) || rdData[$past(reqId[2:0])]); // R1

  AST_UNPLUG_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    goodReq && !reqPlug |=> (int'(rdOffset) != int'($past(reqId[7:3]))) || !rdData[$past(reqId[2:0])]); // R2

  AST_REQ_RAISES_EVT: assert property (@(posedge clk) disable iff (!rstN)
    goodReq |=> evtStatus[2]); // R3

  AST_MAP_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    mapWrValid && !reqValid && (mapWrOffset == rdOffset) && (mapWrData != rdData)
    |=> (rdOffset != $past(rdOffset)) || (rdData == $past(rdData))); // R5

  AST_ONLY_KNOWN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (evtStatus & 8'hF9) == 8'h00); // R7

  AST_SLOT_RAISES_EVT: assert property (@(posedge clk) disable iff (!rstN)
    slotEvtSet |=> evtStatus[1]); // R7

  AST_BAD_ID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    badReq && !stsClrValid |=> errPulse && (evtStatus[2] == $past(evtStatus[2]))); // R8

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !badReq |=> !errPulse); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    goodReq && stsClrValid && stsClrMask[2] |=> evtStatus[2]); // R9

  AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    !goodReq && stsClrValid && stsClrMask[2] |=> !evtStatus[2]); // R9
endmodule

bind cpu_presence_map cpm_checker #(.MAP_BYTES(MAP_BYTES)) u_cpmChecker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqPlug    (reqPlug),
  .reqId      (reqId),
  .rdOffset   (rdOffset),
  .rdData     (rdData),
  .mapWrValid (mapWrValid),
  .mapWrOffset(mapWrOffset),
  .mapWrData  (mapWrData),
  .slotEvtSet (slotEvtSet),
  .stsClrValid(stsClrValid),
  .stsClrMask (stsClrMask),
  .evtStatus  (evtStatus),
  .errPulse   (errPulse)
);

// File: tb/test_cpu_presence_map.sv
module test_cpu_presence_map;
  localparam int MB = 20;
  localparam int OW = $clog2(MB);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [MB*8-1:0] initPresent;
  logic reqValid, reqPlug;
  logic [7:0] reqId;
  logic [OW-1:0] rdOffset;
  logic [7:0] rdData;
  logic mapWrValid;
  logic [OW-1:0] mapWrOffset;
  logic [7:0] mapWrData;
  logic slotEvtSet, stsClrValid;
  logic [7:0] stsClrMask, evtEnable, evtStatus;
  logic irq, errPulse;

  cpu_presence_map #(.MAP_BYTES(MB)) i_cpu_presence_map (
    .clk(clk), .rstN(rstN), .initPresent(initPresent),
    .reqValid(reqValid), .reqPlug(reqPlug), .reqId(reqId),
    .rdOffset(rdOffset), .rdData(rdData),
    .mapWrValid(mapWrValid), .mapWrOffset(mapWrOffset), .mapWrData(mapWrData),
    .slotEvtSet(slotEvtSet), .stsClrValid(stsClrValid), .stsClrMask(stsClrMask),
    .evtEnable(evtEnable), .evtStatus(evtStatus), .irq(irq), .errPulse(errPulse)
  );

  // Behavioural reference
  logic [7:0] refMap [MB];
  logic [7:0] refSts;
  logic       refErr;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input int ofs);
    return (ofs < MB) ? refMap[ofs] : 8'h00;  // R4: unmapped offsets read zero
  endfunction

  task automatic compareAll();
    chk("R1 R2 R4 R5 rdData", rdData, expRead(int'(rdOffset)));
    chk("R3 R7 R9 evtStatus", evtStatus, refSts);
    chk("R10 irq", irq, |(refSts & evtEnable & 8'h06));
    chk("R8 errPulse", errPulse, refErr);
  endtask

  task automatic advanceModel();
    logic [7:0] setB;
    logic [7:0] clrB;
    int bIdx;
    bIdx = int'(reqId) / 8;
    setB = 8'h00;
    refErr = 1'b0;
    if (reqValid) begin
      if (bIdx < MB) begin
        refMap[bIdx][int'(reqId) % 8] = reqPlug;   // R1 R2
        setB[2] = 1'b1;                            // R3
      end else begin
        refErr = 1'b1;                             // R8
      end
    end
    if (slotEvtSet) setB[1] = 1'b1;                // R7
    clrB = stsClrValid ? stsClrMask : 8'h00;
    refSts = ((refSts & ~clrB) | setB) & 8'h06;    // R9: set wins
  endtask

  task automatic step();
    #1;
    compareAll();
    advanceModel();
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic p, input logic [7:0] id,
                       input int ofs, input logic mw, input logic slot,
                       input logic clr, input logic [7:0] mask, input logic [7:0] en);
    reqValid = v; reqPlug = p; reqId = id;
    rdOffset = OW'(ofs);
    mapWrValid = mw; mapWrOffset = OW'(ofs); mapWrData = ~expRead(ofs);
    slotEvtSet = slot; stsClrValid = clr; stsClrMask = mask; evtEnable = en;
    step();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0;
    initPresent = {5{32'hA5C3_0F81}};
    reqValid = 0; reqPlug = 0; reqId = 0; rdOffset = '0;
    mapWrValid = 0; mapWrOffset = '0; mapWrData = 0;
    slotEvtSet = 0; stsClrValid = 0; stsClrMask = 0; evtEnable = 8'hFF;
    for (int b = 0; b < MB; b++) refMap[b] = initPresent[b*8 +: 8];
    refSts = 8'h00;
    refErr = 1'b0;

    // R6: reset state
    repeat (2) @(negedge clk);
    for (int b = 0; b < MB; b += 3) begin
      rdOffset = OW'(b);
      #1;
      chk("R6 reset map byte", rdData, initPresent[b*8 +: 8]);
    end
    chk("R6 reset status", evtStatus, 8'h00);
    chk("R6 reset irq", irq, 1'b0);
    chk("R6 reset errPulse", errPulse, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // Directed cases
    drive(1, 1, 8'd13, 1, 0, 0, 0, 8'h00, 8'h00);   // R1 plug id 13 -> byte 1 bit 5
    drive(0, 0, 8'd0, 1, 0, 0, 0, 8'h00, 8'h04);    // R10 enable after event
    drive(1, 0, 8'd0, 0, 0, 0, 1, 8'h04, 8'h04);    // R2 unplug id 0; R9 set wins clear
    drive(0, 0, 8'd0, 0, 0, 0, 1, 8'h04, 8'h04);    // R9 clear only
    drive(1, 1, 8'd200, 3, 0, 0, 0, 8'h00, 8'hFF);  // R8 out-of-range id
    drive(0, 0, 8'd0, 3, 1, 0, 0, 8'h00, 8'hFF);    // R5 map write dropped
    drive(0, 0, 8'd0, 3, 0, 1, 0, 8'h00, 8'h02);    // R7 slot event
    drive(1, 1, 8'd7, 25, 0, 0, 0, 8'h00, 8'h02);   // R4 unmapped offset, R3 event
    drive(1, 1, 8'd7, 0, 0, 0, 1, 8'hFF, 8'h00);    // R3 plug already-set bit
    drive(0, 0, 8'd0, 0, 0, 0, 1, 8'hFF, 8'hFF);    // R9 clear all

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] id;
      id = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(MB*8, 255))
                                       : 8'($urandom_range(0, MB*8-1));
      drive($urandom_range(0, 9) < 4, 1'($urandom), id,
            $urandom_range(0, (1 << OW) - 1),
            $urandom_range(0, 9) < 3, $urandom_range(0, 9) == 0,
            $urandom_range(0, 9) < 2, 8'($urandom),
            ($urandom_range(0, 7) == 0) ? 8'($urandom) : evtEnable);
    end

    done = 1;
    finishRun();
  end
endmodule